// File: doc/BRIEF.md
# Marker-Driven Timestamp Range Extender

A time-interval front end reports each event as a record made of a channel number, an edge flag and a fine time. The fine time comes from a restart counter whose range is short, on the order of a millisecond. That counter repeats without any notice in the data. To make the counter's period visible, one front-end channel is wired to a delayed copy of the counter's top bit, and both edges of that bit are recorded. Each of these in-band marker records tells the block that half a counter period has gone by.

This block reads the record stream and keeps a running half-period count, which is advanced by every marker. It turns every other record into an absolute timestamp: the full-period count forms the upper part and the fine time forms the lower part. Marker records are used up inside the block and never appear on the output. All other records come out one cycle later, in their input order.

Two more rules cover imperfect input. A marker whose edge matches the previous marker's edge means one transition went missing, so the count advances by two. Because the marker goes through a delay, an event taken just before a wrap can arrive just after the marker that reports that wrap. For a few records after each marker, an event whose fine time lies in the upper half while the count is even is therefore placed in the previous period. The count is `EXT_W` bits wide and wraps modulo 2^`EXT_W` without any indication.

Top module: `ts_range_ext`

## Requirements
- R1: A synchronous reset clears the half-period count to zero, sets the stored marker polarity to falling, and drives `out_vld` low; the first event after reset gets an upper timestamp part of zero.
- R2: A record on channel `MARKER_CH` (default 7) never yields an output; `out_vld` is low in the cycle after it.
- R3: Every valid record on any other channel, with either edge value, yields exactly one output one clock later, with `out_chan` and `out_edge` equal to the input; when `in_vld` is low, no output is produced.
- R4: Bits [`FINE_W`-1:0] of `out_stamp` equal the record's fine time.
- R5: A marker whose edge flag (1 = rising, 0 = falling) differs from the stored polarity adds one to the half-period count; bits above the fine field carry the count divided by two (integer division).
- R6: A marker whose edge flag equals the stored polarity adds two to the half-period count.
- R7: Within the first `SKEW_RECS` (default 2) non-marker records after a marker, a record whose fine-time top bit is 1 while the count is even and nonzero uses the count minus one for its upper part.
- R8: Once `SKEW_RECS` non-marker records have followed the latest marker, no correction is applied, whatever the fine time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input record valid |
| in_chan | input | CH_W | Channel number of the record |
| in_edge | input | 1 | Edge flag, 1 = rising, 0 = falling |
| in_fine | input | FINE_W | Fine time from the restart counter |
| out_vld | output | 1 | Output timestamp valid |
| out_chan | output | CH_W | Channel of the forwarded event |
| out_edge | output | 1 | Edge flag of the forwarded event |
| out_stamp | output | EXT_W+FINE_W-1 | Extended timestamp: period count above fine time |

## Verification
The properties assume at most one record per clock and the default registered output, which gives a latency of exactly one cycle. The step checks assume that the half-period count changes only on marker records. The stimulus drives a single record at each falling edge, with an idle cycle after it. It sends markers in alternating polarity, except for one deliberate repeat that stands for a lost transition. The skew cases are placed directly after a marker, so that both the inside and the outside of the correction window are covered.

// File: rtl/ts_range_ext_pkg.sv
package ts_range_ext_pkg;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_e;

   function automatic logic [1:0] marker_step(input logic new_edge, input logic last_edge);
      return (new_edge == last_edge) ? 2'd2 : 2'd1;
   endfunction

endpackage

// File: rtl/ts_marker_tracker.sv
module ts_marker_tracker
   import ts_range_ext_pkg::*;
#(
   parameter int EXT_W     = 32,
   parameter int SKEW_RECS = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mark_hit,
   input  logic             event_hit,
   input  logic             mark_edge,
   output logic [EXT_W-1:0] half_cnt,
   output logic             win_open
);
   localparam int WIN_W = $clog2(SKEW_RECS + 2);

   logic [EXT_W-1:0] half_q;
   edge_e            pol_q;
   logic [WIN_W-1:0] win_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         half_q <= '0;
         pol_q  <= EDGE_FALL;
         win_q  <= '0;
      end else if (mark_hit) begin
         half_q <= half_q + EXT_W'(marker_step(mark_edge, pol_q));
         pol_q  <= edge_e'(mark_edge);
         win_q  <= WIN_W'(SKEW_RECS);
      end else if (event_hit && (win_q != '0)) begin
         win_q  <= win_q - 1'b1;
      end
   end

   assign half_cnt = half_q;
   assign win_open = (win_q != '0);

endmodule

// File: rtl/ts_event_widener.sv
module ts_event_widener #(
   parameter int EXT_W  = 32,
   parameter int FINE_W = 16,
   localparam int STAMP_W = EXT_W + FINE_W - 1
) (
   input  logic [EXT_W-1:0]   half_cnt,
   input  logic               win_open,
   input  logic [FINE_W-1:0]  fine,
   output logic [STAMP_W-1:0] stamp
);
   logic             late_hit;
   logic [EXT_W-1:0] half_eff;

   // an upper-half sample seen right after an even count belongs before the wrap
   assign late_hit = win_open && fine[FINE_W-1] && !half_cnt[0] && (half_cnt != '0);
   assign half_eff = late_hit ? (half_cnt - 1'b1) : half_cnt;
   assign stamp    = (STAMP_W'(half_eff >> 1) << FINE_W) | STAMP_W'(fine);

endmodule

// File: rtl/ts_out_stage.sv
module ts_out_stage #(
   parameter int CH_W    = 3,
   parameter int STAMP_W = 47,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               d_vld,
   input  logic [CH_W-1:0]    d_chan,
   input  logic               d_edge,
   input  logic [STAMP_W-1:0] d_stamp,
   output logic               q_vld,
   output logic [CH_W-1:0]    q_chan,
   output logic               q_edge,
   output logic [STAMP_W-1:0] q_stamp
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            q_vld   <= 1'b0;
            q_chan  <= '0;
            q_edge  <= 1'b0;
            q_stamp <= '0;
         end else begin
            q_vld   <= d_vld;
            q_chan  <= d_chan;
            q_edge  <= d_edge;
            q_stamp <= d_stamp;
         end
      end
   end else begin : g_wire
      assign q_vld   = d_vld;
      assign q_chan  = d_chan;
      assign q_edge  = d_edge;
      assign q_stamp = d_stamp;
   end

endmodule

// File: rtl/ts_range_ext.sv
module ts_range_ext #(
   parameter int CH_W      = 3,
   parameter int FINE_W    = 16,
   parameter int EXT_W     = 32,
   parameter int MARKER_CH = 7,
   parameter int SKEW_RECS = 2,
   parameter bit OUT_REG   = 1'b1,
   localparam int STAMP_W  = EXT_W + FINE_W - 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_vld,
   input  logic [CH_W-1:0]    in_chan,
   input  logic               in_edge,
   input  logic [FINE_W-1:0]  in_fine,
   output logic               out_vld,
   output logic [CH_W-1:0]    out_chan,
   output logic               out_edge,
   output logic [STAMP_W-1:0] out_stamp
);
   if (FINE_W < 4) begin : g_chk_fine
      $error("ts_range_ext: FINE_W must be at least 4");
   end
   if (EXT_W < 32) begin : g_chk_ext
      $error("ts_range_ext: EXT_W must be at least 32");
   end
   if (MARKER_CH < 0 || MARKER_CH >= (1 << CH_W)) begin : g_chk_mark
      $error("ts_range_ext: MARKER_CH outside channel space");
   end
   if (SKEW_RECS < 0) begin : g_chk_skew
      $error("ts_range_ext: SKEW_RECS must not be negative");
   end

   logic               mark_hit;
   logic               event_hit;
   logic [EXT_W-1:0]   half_cnt;
   logic               win_open;
   logic [STAMP_W-1:0] stamp_d;

   assign mark_hit  = in_vld && (in_chan == CH_W'(MARKER_CH));
   assign event_hit = in_vld && (in_chan != CH_W'(MARKER_CH));

   ts_marker_tracker #(
      .EXT_W     (EXT_W),
      .SKEW_RECS (SKEW_RECS)
   ) i_tracker (
      .clk       (clk),
      .rst       (rst),
      .mark_hit  (mark_hit),
      .event_hit (event_hit),
      .mark_edge (in_edge),
      .half_cnt  (half_cnt),
      .win_open  (win_open)
   );

   ts_event_widener #(
      .EXT_W  (EXT_W),
      .FINE_W (FINE_W)
   ) i_widener (
      .half_cnt (half_cnt),
      .win_open (win_open),
      .fine     (in_fine),
      .stamp    (stamp_d)
   );

   ts_out_stage #(
      .CH_W    (CH_W),
      .STAMP_W (STAMP_W),
      .OUT_REG (OUT_REG)
   ) i_out (
      .clk     (clk),
      .rst     (rst),
      .d_vld   (event_hit),
      .d_chan  (in_chan),
      .d_edge  (in_edge),
      .d_stamp (stamp_d),
      .q_vld   (out_vld),
      .q_chan  (out_chan),
      .q_edge  (out_edge),
      .q_stamp (out_stamp)
   );

endmodule

// File: rtl/ts_range_ext_chk.sv
module ts_range_ext_chk #(
   parameter int CH_W      = 3,
   parameter int FINE_W    = 16,
   parameter int EXT_W     = 32,
   parameter int MARKER_CH = 7,
   localparam int STAMP_W  = EXT_W + FINE_W - 1
) (
   input logic               clk,
   input logic               rst,
   input logic               in_vld,
   input logic [CH_W-1:0]    in_chan,
   input logic               in_edge,
   input logic [FINE_W-1:0]  in_fine,
   input logic               out_vld,
   input logic [CH_W-1:0]    out_chan,
   input logic               out_edge,
   input logic [STAMP_W-1:0] out_stamp,
   input logic [EXT_W-1:0]   half_cnt
);
   logic rst_q;
   logic is_mark;
   logic is_evt;

   assign is_mark = in_vld && (in_chan == CH_W'(MARKER_CH));
   assign is_evt  = in_vld && (in_chan != CH_W'(MARKER_CH));

   always_ff @(posedge clk) rst_q <= rst;

   always @(posedge clk) begin
      if (rst_q && !rst) begin
         p_reset_clear_r1: assert (half_cnt == '0 && !out_vld)
            else $error("reset did not clear state");
      end
   end

   p_marker_hidden_r2: assert property (@(posedge clk) disable iff (rst)
      is_mark |=> !out_vld);

   p_event_fwd_r3: assert property (@(posedge clk) disable iff (rst)
      is_evt |=> (out_vld && out_chan == $past(in_chan) && out_edge == $past(in_edge)));

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);

   p_fine_kept_r4: assert property (@(posedge clk) disable iff (rst)
      is_evt |=> (out_stamp[FINE_W-1:0] == $past(in_fine)));

   p_hold_count_r5: assert property (@(posedge clk) disable iff (rst)
      !is_mark |=> $stable(half_cnt));

   p_step_size_r6: assert property (@(posedge clk) disable iff (rst)
      is_mark |=> ((half_cnt - $past(half_cnt)) == EXT_W'(1) ||
                   (half_cnt - $past(half_cnt)) == EXT_W'(2)));

endmodule

bind ts_range_ext ts_range_ext_chk #(
   .CH_W      (CH_W),
   .FINE_W    (FINE_W),
   .EXT_W     (EXT_W),
   .MARKER_CH (MARKER_CH)
) i_ts_range_ext_chk (
   .clk       (clk),
   .rst       (rst),
   .in_vld    (in_vld),
   .in_chan   (in_chan),
   .in_edge   (in_edge),
   .in_fine   (in_fine),
   .out_vld   (out_vld),
   .out_chan  (out_chan),
   .out_edge  (out_edge),
   .out_stamp (out_stamp),
   .half_cnt  (half_cnt)
);

// File: tb/test_ts_range_ext.sv
module test_ts_range_ext;
   localparam int CH_W    = 3;
   localparam int FINE_W  = 16;
   localparam int EXT_W   = 32;
   localparam int STAMP_W = EXT_W + FINE_W - 1;
   localparam int MARK    = 7;
   localparam int SKEW    = 2;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               in_vld = 1'b0;
   logic [CH_W-1:0]    in_chan = '0;
   logic               in_edge = 1'b0;
   logic [FINE_W-1:0]  in_fine = '0;
   logic               out_vld;
   logic [CH_W-1:0]    out_chan;
   logic               out_edge;
   logic [STAMP_W-1:0] out_stamp;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [EXT_W-1:0] m_half = '0;
   logic             m_pol  = 1'b0;
   int               m_win  = 0;

   always #4 clk = ~clk;

   ts_range_ext #(
      .CH_W(CH_W), .FINE_W(FINE_W), .EXT_W(EXT_W), .MARKER_CH(MARK), .SKEW_RECS(SKEW)
   ) i_ts_range_ext (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_chan(in_chan), .in_edge(in_edge),
      .in_fine(in_fine), .out_vld(out_vld), .out_chan(out_chan), .out_edge(out_edge),
      .out_stamp(out_stamp)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one record, checked one cycle later, followed by an idle cycle
   task automatic send(input logic [CH_W-1:0] ch, input logic ed,
                       input logic [FINE_W-1:0] fine, input string req);
      logic [EXT_W-1:0]   heff;
      logic [STAMP_W-1:0] exp;
      bit                 is_mark;
      @(negedge clk);
      in_vld = 1'b1; in_chan = ch; in_edge = ed; in_fine = fine;
      is_mark = (ch == CH_W'(MARK));
      heff = m_half;
      if (!is_mark && m_win != 0 && fine[FINE_W-1] && !m_half[0] && m_half != '0)
         heff = m_half - 1'b1;
      exp = {heff[EXT_W-1:1], fine};
      if (is_mark) begin
         m_half = m_half + ((ed == m_pol) ? 2 : 1);
         m_pol  = ed;
         m_win  = SKEW;
      end else if (m_win != 0) begin
         m_win--;
      end
      @(posedge clk); #1;
      if (is_mark) begin
         check(out_vld == 1'b0, req, "marker out_vld", 64'(out_vld), 64'd0);
      end else begin
         check(out_vld == 1'b1, req, "out_vld", 64'(out_vld), 64'd1);
         check(out_chan == ch && out_edge == ed, req, "chan/edge",
               64'({out_chan, out_edge}), 64'({ch, ed}));
         check(out_stamp == exp, req, "stamp", 64'(out_stamp), 64'(exp));
      end
      @(negedge clk);
      in_vld = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      @(posedge clk); #1;
      check(out_vld == 1'b0, "R1", "out_vld after reset", 64'(out_vld), 64'd0);
      send(3'd0, 1'b1, 16'h1234, "R1");
      send(3'd1, 1'b0, 16'hABCD, "R4");
   endtask

   task automatic t_marker_steps();
      send(3'(MARK), 1'b1, 16'h0000, "R2");
      send(3'd2, 1'b1, 16'h9000, "R5");
      send(3'(MARK), 1'b0, 16'h0000, "R2");
      send(3'd3, 1'b0, 16'h0100, "R5");
   endtask

   task automatic t_skew_window();
      send(3'(MARK), 1'b1, 16'h0000, "R5");
      send(3'd0, 1'b1, 16'h7000, "R5");
      send(3'(MARK), 1'b0, 16'h0000, "R5");
      send(3'd4, 1'b1, 16'hF000, "R7");
      send(3'd5, 1'b0, 16'hF100, "R7");
      send(3'd0, 1'b1, 16'hF200, "R8");
   endtask

   task automatic t_lost_transition();
      send(3'(MARK), 1'b0, 16'h0000, "R6");
      send(3'd1, 1'b1, 16'h0010, "R6");
      send(3'(MARK), 1'b1, 16'h0000, "R6");
      send(3'd2, 1'b0, 16'hC000, "R6");
   endtask

   task automatic t_channel_sweep();
      for (int c = 0; c < 7; c++) begin
         send(3'(c), 1'b1, 16'(16'h2000 + c), "R3");
         send(3'(c), 1'b0, 16'(16'h2100 + c), "R3");
      end
      @(posedge clk); #1;
      check(out_vld == 1'b0, "R3", "idle out_vld", 64'(out_vld), 64'd0);
   endtask

   initial begin
      t_reset();
      t_marker_steps();
      t_skew_window();
      t_lost_transition();
      t_channel_sweep();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule